// File: doc/BRIEF.md
# Paced Two-Port Transfer Engine

This block copies bytes between two endpoints, called port A and port B, over a simple processor-style bus on which it acts as the bus master. Each byte is moved in two steps. A read cycle fetches the byte from the source port into a holding register. A write cycle then delivers it to the destination port. Each port keeps its own address pointer, which can count down, count up or stay put after every byte. Each port also has a flag that marks it as memory or IO space, and its own access length of 2, 3 or 4 clocks.

The engine counts bytes against a programmed block length. It has two counting modes: a native mode and a compatibility mode that moves one extra byte. It can restart itself at the end of every block. A prescaler can fix the time spent on each byte. The bus is requested with a request/grant pair. In continuous ownership the request stays asserted through the whole block, including any paced wait. In burst ownership the request is dropped while the engine waits out the pacing interval.

Configuration arrives already decoded, on plain inputs that must stay stable while the engine runs. Single-cycle command strobes load the pointers, enable, disable and resume the engine. The bus side has no back-pressure: once granted, every access runs for its fixed length.

Top module: `paced_xfer_engine`

## Requirements
- R1: With `cfg_a_to_b`=1, the read cycle uses port A's pointer and IO flag and the write cycle uses port B's. With `cfg_a_to_b`=0 the roles are swapped.
- R2: Step code 2'b00 lowers a port's pointer by one after each byte through that port. 2'b01 raises it by one. 2'b10 and 2'b11 leave it unchanged.
- R3: `bus_io` equals the IO flag of the port being accessed during its read or write cycle (1 = IO space, 0 = memory).
- R4: Access-length code 2'b00 gives 4 clocks, 2'b01 gives 3, and 2'b10 or 2'b11 gives 2. The strobe (`bus_rd` or `bus_wr`) is high in every clock of the access except the last, and `bus_rd` and `bus_wr` are never high together.
- R5: In native mode (`cfg_compat`=0) a block moves exactly `cfg_len` bytes. A length of zero moves nothing and ends the block at once.
- R6: With `cfg_compat`=1 a block moves `cfg_len`+1 bytes.
- R7: With a non-zero prescaler P, consecutive bytes start P*32 clocks apart, or back to back if the two accesses take longer than that. In continuous mode `bus_req` stays high through the wait.
- R8: In burst mode (`cfg_burst`=1) `bus_req` is low for the whole pacing wait and is raised again for the next byte.
- R9: With `cfg_autorestart`=1, at the end of a block both pointers reload from their start values, the count restarts, and the next byte follows without a stop.
- R10: `stat_blk_open` is set and `stat_moved` is cleared by a load. `stat_blk_open` drops once a whole block has been moved. `stat_moved` rises when the first byte has been written.
- R11: A continue strobe clears the byte count but keeps both pointers, so the next enable resumes from the addresses where the last transfer stopped.
- R12: A byte's read cycle starts only after `bus_gnt` has been seen with `bus_req` high. After a disable no new byte starts, but a byte already in flight completes.
- R13: With prescaler zero and continuous ownership, the read of the next byte follows the last clock of the previous write directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_a_to_b | input | 1 | 1: port A to port B, 0: port B to port A |
| cfg_a_step | input | 2 | Port A pointer step code |
| cfg_a_io | input | 1 | Port A is IO space |
| cfg_a_cyc | input | 2 | Port A access-length code |
| cfg_a_start | input | AW | Port A start address |
| cfg_b_step | input | 2 | Port B pointer step code |
| cfg_b_io | input | 1 | Port B is IO space |
| cfg_b_cyc | input | 2 | Port B access-length code |
| cfg_b_start | input | AW | Port B start address |
| cfg_len | input | LW | Block length in bytes |
| cfg_prescale | input | PW | Per-byte pacing factor, 0 = unpaced |
| cfg_burst | input | 1 | 1: burst ownership, 0: continuous |
| cfg_autorestart | input | 1 | Repeat the block when it ends |
| cfg_compat | input | 1 | Move length+1 bytes per block |
| cmd_load | input | 1 | Load pointers, clear count, reset status (while idle) |
| cmd_enable | input | 1 | Start or resume the engine |
| cmd_disable | input | 1 | Stop after the byte in flight |
| cmd_continue | input | 1 | Clear the count, keep the pointers (while idle) |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | AW | Access address |
| bus_io | output | 1 | Access targets IO space |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_rdata | input | DW | Read data |
| bus_wdata | output | DW | Write data |
| busy | output | 1 | Engine enabled or a cycle in progress |
| stat_blk_open | output | 1 | No full block moved since the last load |
| stat_moved | output | 1 | At least one byte moved since the last load |

## Verification
An enable sampled at one clock edge shows up as `bus_req` two clocks later, and with an immediate grant the first read clock follows one clock after that. Each access then lasts its coded length, and a paced byte starts exactly P*32 clocks after the previous one. Burst re-requests add the grant latency on top of that. The bench builds the full expected per-clock trace of request, strobes, address, space flag and write data from these latencies, and compares it on the falling edge of every clock. A disable is injected on a known read clock, and status is checked once the trailing idle clocks confirm that nothing else starts. Grant is given either at once or only after four clocks of continuous request, so that both latencies are covered.

// File: rtl/pxe_pkg.sv
package pxe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RD,
    ST_WR,
    ST_GAP
  } pxe_state_e;

  // Index of the final clock of an access: code 00 -> 4 clocks, 01 -> 3, else 2.
  function automatic logic [1:0] last_tick(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd3;
      2'b01:   return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/pxe_ptr.sv
module pxe_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic [AW-1:0] start,
  input  logic          step_en,
  input  logic [1:0]    mode,
  output logic [AW-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (reload) begin
      ptr <= start;
    end else if (step_en) begin
      case (mode)
        2'b00:   ptr <= ptr - AW'(1);
        2'b01:   ptr <= ptr + AW'(1);
        default: ptr <= ptr;
      endcase
    end
  end

endmodule

// File: rtl/pxe_pacer.sv
module pxe_pacer #(
  parameter int PW   = 8,
  parameter int UNIT = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [PW-1:0] prescale,
  output logic          due
);

  localparam int PERW = $clog2(UNIT * ((1 << PW) - 1) + 1);

  logic [PERW-1:0] cnt;
  logic [PERW-1:0] period;

  assign period = PERW'(prescale) * PERW'(UNIT);
  assign due    = (prescale == '0) || (cnt >= period - PERW'(1));

  // Clocks elapsed since the current byte's first read clock, saturating.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (cnt != '1) begin
      cnt <= cnt + PERW'(1);
    end
  end

endmodule

// File: rtl/pxe_blkcnt.sv
module pxe_blkcnt #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          incr,
  input  logic [LW-1:0] len,
  input  logic          compat,
  output logic          empty,
  output logic          last
);

  localparam int CW = LW + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] target;

  assign target = {1'b0, len} + CW'(compat);
  assign empty  = (cnt >= target);
  assign last   = ((cnt + CW'(1)) == target);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (incr) begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/paced_xfer_engine.sv
module paced_xfer_engine
  import pxe_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int LW        = 16,
  parameter int PW        = 8,
  parameter int PACE_UNIT = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_a_to_b,
  input  logic [1:0]    cfg_a_step,
  input  logic          cfg_a_io,
  input  logic [1:0]    cfg_a_cyc,
  input  logic [AW-1:0] cfg_a_start,
  input  logic [1:0]    cfg_b_step,
  input  logic          cfg_b_io,
  input  logic [1:0]    cfg_b_cyc,
  input  logic [AW-1:0] cfg_b_start,
  input  logic [LW-1:0] cfg_len,
  input  logic [PW-1:0] cfg_prescale,
  input  logic          cfg_burst,
  input  logic          cfg_autorestart,
  input  logic          cfg_compat,
  input  logic          cmd_load,
  input  logic          cmd_enable,
  input  logic          cmd_disable,
  input  logic          cmd_continue,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] bus_addr,
  output logic          bus_io,
  output logic          bus_rd,
  output logic          bus_wr,
  input  logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] bus_wdata,
  output logic          busy,
  output logic          stat_blk_open,
  output logic          stat_moved
);

  localparam int NPORT = 2;

  pxe_state_e    state, nstate;
  logic [1:0]    cc, cc_n;
  logic          run;
  logic [DW-1:0] hold;

  logic [AW-1:0] start_v [NPORT];
  logic [AW-1:0] ptr_v   [NPORT];
  logic [1:0]    step_v  [NPORT];
  logic [1:0]    cyc_v   [NPORT];
  logic          io_v    [NPORT];

  logic src_i, dst_i;
  logic [1:0] src_last, dst_last;
  logic run_eff, idle, go_load, go_cont;
  logic byte_go, src_step, dst_step, cnt_inc, blk_end, restart, stop, cap;
  logic ptr_reload, cnt_empty, cnt_last, pace_due;

  assign start_v[0] = cfg_a_start;
  assign start_v[1] = cfg_b_start;
  assign step_v[0]  = cfg_a_step;
  assign step_v[1]  = cfg_b_step;
  assign cyc_v[0]   = cfg_a_cyc;
  assign cyc_v[1]   = cfg_b_cyc;
  assign io_v[0]    = cfg_a_io;
  assign io_v[1]    = cfg_b_io;

  // Index 0 is port A, index 1 is port B.
  assign src_i    = ~cfg_a_to_b;
  assign dst_i    = cfg_a_to_b;
  assign src_last = last_tick(cyc_v[src_i]);
  assign dst_last = last_tick(cyc_v[dst_i]);

  assign run_eff    = run & ~cmd_disable;
  assign idle       = (state == ST_IDLE) && !run;
  assign go_load    = cmd_load & idle;
  assign go_cont    = cmd_continue & idle;
  assign ptr_reload = go_load | restart;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pxe_ptr #(.AW(AW)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .reload  (ptr_reload),
      .start   (start_v[p]),
      .step_en ((src_step && (src_i == 1'(p))) || (dst_step && (dst_i == 1'(p)))),
      .mode    (step_v[p]),
      .ptr     (ptr_v[p])
    );
  end

  pxe_blkcnt #(.LW(LW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (go_load | go_cont | restart),
    .incr   (cnt_inc),
    .len    (cfg_len),
    .compat (cfg_compat),
    .empty  (cnt_empty),
    .last   (cnt_last)
  );

  pxe_pacer #(.PW(PW), .UNIT(PACE_UNIT)) u_pace (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (byte_go),
    .prescale (cfg_prescale),
    .due      (pace_due)
  );

  always_comb begin
    nstate   = state;
    cc_n     = cc;
    byte_go  = 1'b0;
    src_step = 1'b0;
    dst_step = 1'b0;
    cnt_inc  = 1'b0;
    blk_end  = 1'b0;
    restart  = 1'b0;
    stop     = 1'b0;
    cap      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (run_eff) begin
          if (cnt_empty) begin
            blk_end = 1'b1;
            stop    = 1'b1;
          end else begin
            nstate = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        if (!run_eff) begin
          nstate = ST_IDLE;
        end else if (bus_gnt) begin
          nstate  = ST_RD;
          cc_n    = 2'd0;
          byte_go = 1'b1;
        end
      end
      ST_RD: begin
        if (cc == src_last - 2'd1) cap = 1'b1;
        if (cc == src_last) begin
          src_step = 1'b1;
          nstate   = ST_WR;
          cc_n     = 2'd0;
        end else begin
          cc_n = cc + 2'd1;
        end
      end
      ST_WR: begin
        if (cc == dst_last) begin
          dst_step = 1'b1;
          cnt_inc  = 1'b1;
          cc_n     = 2'd0;
          if (cnt_last) begin
            blk_end = 1'b1;
            if (cfg_autorestart) restart = 1'b1;
            else                 stop    = 1'b1;
          end
          if ((cnt_last && !cfg_autorestart) || !run_eff) begin
            nstate = ST_IDLE;
          end else if (pace_due) begin
            nstate  = ST_RD;
            byte_go = 1'b1;
          end else begin
            nstate = ST_GAP;
          end
        end else begin
          cc_n = cc + 2'd1;
        end
      end
      ST_GAP: begin
        if (!run_eff) begin
          nstate = ST_IDLE;
        end else if (pace_due) begin
          if (cfg_burst) begin
            nstate = ST_REQ;
          end else begin
            nstate  = ST_RD;
            cc_n    = 2'd0;
            byte_go = 1'b1;
          end
        end
      end
      default: nstate = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      cc            <= 2'd0;
      run           <= 1'b0;
      hold          <= '0;
      stat_blk_open <= 1'b1;
      stat_moved    <= 1'b0;
    end else begin
      state <= nstate;
      cc    <= cc_n;
      if (cap) hold <= bus_rdata;
      if (cmd_disable || stop) run <= 1'b0;
      else if (cmd_enable)     run <= 1'b1;
      if (go_load)      stat_blk_open <= 1'b1;
      else if (blk_end) stat_blk_open <= 1'b0;
      if (go_load)      stat_moved <= 1'b0;
      else if (cnt_inc) stat_moved <= 1'b1;
    end
  end

  always_comb begin
    bus_req   = (state == ST_REQ) || (state == ST_RD) || (state == ST_WR) ||
                ((state == ST_GAP) && !cfg_burst);
    bus_rd    = (state == ST_RD) && (cc < src_last);
    bus_wr    = (state == ST_WR) && (cc < dst_last);
    bus_wdata = hold;
    if (state == ST_RD) begin
      bus_addr = ptr_v[src_i];
      bus_io   = io_v[src_i];
    end else if (state == ST_WR) begin
      bus_addr = ptr_v[dst_i];
      bus_io   = io_v[dst_i];
    end else begin
      bus_addr = '0;
      bus_io   = 1'b0;
    end
    busy = run || (state != ST_IDLE);
  end

endmodule

// File: rtl/pxe_checker.sv
module pxe_checker (
  input logic clk,
  input logic rst_n,
  input logic bus_req,
  input logic bus_gnt,
  input logic bus_rd,
  input logic bus_wr,
  input logic busy,
  input logic cfg_burst,
  input logic cmd_load,
  input logic stat_blk_open,
  input logic stat_moved
);

  p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  p_strobe_needs_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> bus_req);

  p_read_after_grant_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd) |-> $past(bus_gnt));

  p_cont_keeps_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !cfg_burst && busy) |=> (bus_req || !busy));

  p_moved_cleared_by_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_moved) |-> $past(cmd_load));

  p_open_set_by_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_blk_open) |-> $past(cmd_load));

endmodule

bind paced_xfer_engine pxe_checker u_pxe_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_req       (bus_req),
  .bus_gnt       (bus_gnt),
  .bus_rd        (bus_rd),
  .bus_wr        (bus_wr),
  .busy          (busy),
  .cfg_burst     (cfg_burst),
  .cmd_load      (cmd_load),
  .stat_blk_open (stat_blk_open),
  .stat_moved    (stat_moved)
);

// File: tb/paced_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module paced_xfer_engine_tb_top;

  function automatic logic [7:0] fdat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  function automatic int clks(input bit [1:0] c);
    return (c == 2'b00) ? 4 : (c == 2'b01) ? 3 : 2;
  endfunction

  function automatic bit [15:0] adv(input bit [15:0] a, input bit [1:0] m);
    case (m)
      2'b00:   return a - 16'd1;
      2'b01:   return a + 16'd1;
      default: return a;
    endcase
  endfunction

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic cfg_a_to_b, cfg_a_io, cfg_b_io, cfg_burst, cfg_autorestart, cfg_compat;
  logic [1:0] cfg_a_step, cfg_a_cyc, cfg_b_step, cfg_b_cyc;
  logic [15:0] cfg_a_start, cfg_b_start, cfg_len;
  logic [7:0] cfg_prescale;
  logic cmd_load, cmd_enable, cmd_disable, cmd_continue;
  logic bus_req, bus_gnt, bus_io, bus_rd, bus_wr, busy, stat_blk_open, stat_moved;
  logic [15:0] bus_addr;
  logic [7:0] bus_rdata, bus_wdata;

  logic slow_gnt = 1'b0;
  logic [2:0] gd = 3'b000;
  always_ff @(posedge clk) gd <= {gd[1:0], bus_req};
  assign bus_gnt   = slow_gnt ? (bus_req & gd[0] & gd[1] & gd[2]) : bus_req;
  assign bus_rdata = fdat(bus_addr);

  paced_xfer_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_a_to_b(cfg_a_to_b), .cfg_a_step(cfg_a_step), .cfg_a_io(cfg_a_io),
    .cfg_a_cyc(cfg_a_cyc), .cfg_a_start(cfg_a_start),
    .cfg_b_step(cfg_b_step), .cfg_b_io(cfg_b_io), .cfg_b_cyc(cfg_b_cyc),
    .cfg_b_start(cfg_b_start), .cfg_len(cfg_len), .cfg_prescale(cfg_prescale),
    .cfg_burst(cfg_burst), .cfg_autorestart(cfg_autorestart), .cfg_compat(cfg_compat),
    .cmd_load(cmd_load), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .cmd_continue(cmd_continue),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_io(bus_io),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_wdata(bus_wdata),
    .busy(busy), .stat_blk_open(stat_blk_open), .stat_moved(stat_moved)
  );

  typedef struct {
    bit        req;
    bit        rd;
    bit        wr;
    bit        io;
    bit [15:0] addr;
    bit [7:0]  wd;
  } exp_t;

  exp_t q[$];
  int   bstart[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // Reference state
  bit [15:0] pa, pb;
  int        mcnt;
  bit        mE, mT;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic push(input bit r, input bit rd, input bit wr, input bit io,
                      input bit [15:0] a, input bit [7:0] d);
    exp_t e;
    e.req = r; e.rd = rd; e.wr = wr; e.io = io; e.addr = a; e.wd = d;
    q.push_back(e);
  endtask

  task automatic build(input int nb, input int g);
    int tgt;
    tgt = int'(cfg_len) + int'(cfg_compat);
    q.delete();
    bstart.delete();
    push(0, 0, 0, 0, 16'h0, 8'h0);
    if (nb > 0) repeat (g) push(1, 0, 0, 0, 16'h0, 8'h0);
    for (int b = 0; b < nb; b++) begin
      bit [15:0] s, d;
      bit        sio, dio;
      int        ls, ld, per;
      bit [7:0]  dat;
      s   = cfg_a_to_b ? pa : pb;
      d   = cfg_a_to_b ? pb : pa;
      sio = cfg_a_to_b ? cfg_a_io : cfg_b_io;
      dio = cfg_a_to_b ? cfg_b_io : cfg_a_io;
      ls  = clks(cfg_a_to_b ? cfg_a_cyc : cfg_b_cyc);
      ld  = clks(cfg_a_to_b ? cfg_b_cyc : cfg_a_cyc);
      dat = fdat(s);
      bstart.push_back(q.size());
      for (int c = 0; c < ls; c++) push(1, c < ls - 1, 0, sio, s, 8'h0);
      if (cfg_a_to_b) pa = adv(pa, cfg_a_step); else pb = adv(pb, cfg_b_step);
      for (int c = 0; c < ld; c++) push(1, 0, c < ld - 1, dio, d, dat);
      if (cfg_a_to_b) pb = adv(pb, cfg_b_step); else pa = adv(pa, cfg_a_step);
      mT = 1'b1;
      mcnt++;
      if (mcnt == tgt) begin
        mE = 1'b0;
        if (cfg_autorestart) begin
          pa = cfg_a_start; pb = cfg_b_start; mcnt = 0;
        end
      end
      if (b < nb - 1) begin
        per = int'(cfg_prescale) * 32;
        if (cfg_prescale != 0 && per > ls + ld) begin
          repeat (per - ls - ld) push(!cfg_burst, 0, 0, 0, 16'h0, 8'h0);
          if (cfg_burst) repeat (g) push(1, 0, 0, 0, 16'h0, 8'h0);
        end
      end
    end
    if (nb == 0 && mcnt >= tgt) mE = 1'b0;
    repeat (3) push(0, 0, 0, 0, 16'h0, 8'h0);
  endtask

  task automatic run(input string tag, input int nb, input int g, input int dis_byte);
    int di;
    build(nb, g);
    di = (dis_byte >= 0) ? bstart[dis_byte] : -1;
    @(negedge clk) cmd_enable = 1'b1;
    for (int i = 0; i < q.size(); i++) begin
      bit ok;
      @(negedge clk);
      ok = (bus_req === q[i].req) && (bus_rd === q[i].rd) && (bus_wr === q[i].wr);
      if (q[i].rd || q[i].wr) ok = ok && (bus_addr === q[i].addr) && (bus_io === q[i].io);
      if (q[i].wr) ok = ok && (bus_wdata === q[i].wd);
      n_cmp++;
      if (!ok) begin
        n_bad++;
        $display("FAIL %s cycle %0d: actual req%b rd%b wr%b io%b a=%h d=%h expected req%b rd%b wr%b io%b a=%h d=%h",
                 tag, i, bus_req, bus_rd, bus_wr, bus_io, bus_addr, bus_wdata,
                 q[i].req, q[i].rd, q[i].wr, q[i].io, q[i].addr, q[i].wd);
      end
      cmd_enable  = 1'b0;
      cmd_disable = (i == di);
    end
    cmd_disable = 1'b0;
    chk(tag, "busy", busy, 1'b0);
    chk(tag, "stat_blk_open", stat_blk_open, mE);
    chk(tag, "stat_moved", stat_moved, mT);
  endtask

  task automatic do_load();
    @(negedge clk) cmd_load = 1'b1;
    @(negedge clk) cmd_load = 1'b0;
    pa = cfg_a_start; pb = cfg_b_start; mcnt = 0; mE = 1'b1; mT = 1'b0;
  endtask

  task automatic do_continue();
    @(negedge clk) cmd_continue = 1'b1;
    @(negedge clk) cmd_continue = 1'b0;
    mcnt = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R12 watchdog: actual still running expected finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    cmd_load = 0; cmd_enable = 0; cmd_disable = 0; cmd_continue = 0;
    cfg_a_to_b = 1; cfg_a_step = 2'b01; cfg_a_io = 0; cfg_a_cyc = 2'b10;
    cfg_a_start = 16'h1000;
    cfg_b_step = 2'b01; cfg_b_io = 1; cfg_b_cyc = 2'b00; cfg_b_start = 16'h2040;
    cfg_len = 16'd3; cfg_prescale = 8'd0; cfg_burst = 0; cfg_autorestart = 0;
    cfg_compat = 0;
    pa = 0; pb = 0; mcnt = 0; mE = 1; mT = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset", "bus_req", bus_req, 1'b0);
    chk("R10 reset", "busy", busy, 1'b0);
    chk("R10 reset", "stat_blk_open", stat_blk_open, 1'b1);
    chk("R10 reset", "stat_moved", stat_moved, 1'b0);

    // A to B, A memory inc 2 clocks, B IO inc 4 clocks, native, unpaced
    do_load();
    run("R1 R2 R3 R4 R5 R13 R10", 3, 1, -1);

    // Resume from where the pointers stopped
    do_continue();
    run("R11", 3, 1, -1);

    // B to A, A decrements, B fixed, 3-clock accesses, compat length
    cfg_a_to_b = 0; cfg_a_step = 2'b00; cfg_b_step = 2'b10;
    cfg_a_cyc = 2'b01; cfg_b_cyc = 2'b01; cfg_a_io = 1; cfg_b_io = 0;
    cfg_len = 16'd2; cfg_compat = 1; cfg_b_start = 16'h0077;
    do_load();
    chk("R10 load", "stat_blk_open", stat_blk_open, 1'b1);
    chk("R10 load", "stat_moved", stat_moved, 1'b0);
    run("R6 R1 R2 R3", 3, 1, -1);

    // Paced, continuous ownership
    cfg_a_to_b = 1; cfg_a_step = 2'b01; cfg_b_step = 2'b11;
    cfg_a_cyc = 2'b10; cfg_b_cyc = 2'b10; cfg_compat = 0;
    cfg_len = 16'd2; cfg_prescale = 8'd1;
    do_load();
    run("R7", 2, 1, -1);

    // Paced, burst ownership, slow grant
    cfg_burst = 1; slow_gnt = 1;
    do_load();
    run("R8 R12", 2, 4, -1);

    // Auto restart, stopped by a disable during the fifth byte
    cfg_burst = 0; slow_gnt = 0; cfg_prescale = 8'd0; cfg_autorestart = 1;
    cfg_b_step = 2'b00; cfg_a_start = 16'h3FFE; cfg_b_start = 16'h0001;
    do_load();
    run("R9 R12", 5, 1, 4);

    // Zero length in native mode
    cfg_autorestart = 0; cfg_len = 16'd0;
    do_load();
    run("R5 zero", 0, 1, -1);

    done = 1'b1;
    finish_run();
  end

endmodule